// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives an SPI serial clock from the main clock through two divide stages in sequence. The first stage is a power-of-two prescaler that divides by 2, 4, 8 or 16, chosen by a 2-bit prescale field. The second stage is an even divider that divides by 2*(N+1), where N is a 6-bit rate field. N has a floor of 4, which sets the fastest legal serial clock at one twentieth of the main clock. The slowest legal serial clock is main/2048. Both stages are merged into a single counter. The serial clock changes level each time that counter reaches its terminal count. A one-cycle tick marks every level change.

The two fields come from one of two sources. Software can supply them directly, or a built-in solver can choose them from a requested main-to-serial clock ratio. The solver takes the smallest prescale setting that keeps the rate field inside its legal window. It clamps requests that are too fast to the fastest setting and requests that are too slow to the slowest setting. The applied fields are shown on the outputs. Clock polarity and data shifting belong to the neighbouring shift engine.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, the applied settings are prescale 0 and rate 4, and `sclk` and `tick` are both 0.
- R2: With `en` high and the settings unchanged, `sclk` stays at each level for exactly (rate+1) << (prescale+1) main clock cycles. The full period is therefore main/20 at (0,4) and main/2048 at (3,63).
- R3: A manual rate value below 4 is applied as 4. Manual rate values from 4 to 63 are applied unchanged.
- R4: In solver mode, the block computes q(d) = floor(ratio / (4 << d)) for d = 0, 1, 2, 3. It picks the smallest d with q(d) <= 64 and applies prescale d with rate q(d)-1.
- R5: In solver mode, if q(d) at the chosen d is below 5, the rate is applied as 4 at that d. A ratio of 0 gives prescale 0 and rate 4.
- R6: In solver mode, if no d from 0 to 3 has q(d) <= 64, the block applies prescale 3 and rate 63.
- R7: While `en` is low, `sclk` is held at 0 and `tick` stays 0.
- R8: `tick` is high for exactly one cycle at each counted `sclk` level change, in the cycle in which the new level first appears.
- R9: When the applied settings change, `sclk` returns to 0 on the clock edge that loads them, and the count restarts. The first new level change then follows a full new half period later. When `en` rises with the settings unchanged, the first change likewise comes one half period after the rise.
- R10: With `use_solver` = 1 the solver result is applied and the manual fields have no effect. With `use_solver` = 0 the manual fields are applied and `ratio` has no effect. `div_out` and `brg_out` show the applied values one clock after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Runs the serial clock when high |
| use_solver | input | 1 | 1: settings come from the solver; 0: settings come from the manual fields |
| man_div | input | 2 | Manual prescale field (divide by 2 << value) |
| man_brg | input | 6 | Manual rate field (divide by 2*(value+1)) |
| ratio | input | RATIO_W (16) | Requested main-to-serial clock ratio for the solver |
| sclk | output | 1 | Serial clock, idle level 0 |
| tick | output | 1 | One-cycle strobe at each serial clock level change |
| div_out | output | 2 | Applied prescale field |
| brg_out | output | 6 | Applied rate field |

## Verification
A fault in the solver or the field clamp appears at `div_out` and `brg_out` one clock after the inputs change, so those faults are caught before any serial clock period passes. A fault in the merged counter's terminal count shows up as a wrong spacing between consecutive `tick` pulses. That error is visible within one half period, which is at most 1024 cycles. A missed restart or a missed idle hold shows up at `sclk` on the first edge after the configuration change or after `en` falls.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
   localparam int DIV_W  = 2;
   localparam int BRG_W  = 6;
   localparam int NDIV   = 1 << DIV_W;
   localparam int CNT_W  = BRG_W + NDIV;

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic [BRG_W-1:0] brg;
   } sbg_cfg_t;
endpackage

// File: rtl/sbg_solver.sv
module sbg_solver
   import sbg_pkg::*;
#(
   parameter int RATIO_W = 16,
   parameter int BRG_MIN = 4
) (
   input  logic [RATIO_W-1:0] ratio,
   output sbg_cfg_t           sol
);
   localparam int BRG_SPAN = 1 << BRG_W;

   logic [NDIV-1:0]  fits;
   logic [BRG_W-1:0] cand_brg [NDIV];

   // one candidate per prescale setting
   for (genvar d = 0; d < NDIV; d++) begin : g_cand
      logic [RATIO_W-1:0] quot;
      assign quot        = ratio >> (d + 2);
      assign fits[d]     = (quot <= RATIO_W'(BRG_SPAN));
      assign cand_brg[d] = (quot < RATIO_W'(BRG_MIN + 1)) ? BRG_W'(BRG_MIN)
                                                         : BRG_W'(quot - 1'b1);
   end

   // lowest fitting prescale wins; slowest setting when none fits
   always_comb begin
      sol.div = DIV_W'(NDIV - 1);
      sol.brg = BRG_W'(BRG_SPAN - 1);
      for (int d = NDIV - 1; d >= 0; d--) begin
         if (fits[d]) begin
            sol.div = DIV_W'(d);
            sol.brg = cand_brg[d];
         end
      end
   end
endmodule

// File: rtl/sbg_select.sv
module sbg_select
   import sbg_pkg::*;
#(
   parameter int BRG_MIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_solver,
   input  logic [DIV_W-1:0] man_div,
   input  logic [BRG_W-1:0] man_brg,
   input  sbg_cfg_t         sol,
   output sbg_cfg_t         cfg,
   output logic             chg
);
   sbg_cfg_t man_cfg;
   sbg_cfg_t nxt_cfg;

   always_comb begin
      man_cfg.div = man_div;
      man_cfg.brg = (man_brg < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : man_brg;
   end

   assign nxt_cfg = use_solver ? sol : man_cfg;
   assign chg     = (nxt_cfg != cfg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.div <= '0;
         cfg.brg <= BRG_W'(BRG_MIN);
      end else begin
         cfg <= nxt_cfg;
      end
   end

   // R3
   brg_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.brg >= BRG_W'(BRG_MIN));
endmodule

// File: rtl/sbg_divider.sv
module sbg_divider
   import sbg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     chg,
   input  sbg_cfg_t cfg,
   output logic     sclk,
   output logic     tick
);
   logic [CNT_W:0]   brg_p1;
   logic [CNT_W:0]   half;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt;

   // half period = (brg+1) << (div+1) main cycles
   assign brg_p1 = (CNT_W+1)'(cfg.brg) + (CNT_W+1)'(1);
   assign half   = brg_p1 << ({1'b0, cfg.div} + 1'b1);
   assign term   = CNT_W'(half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
         tick <= 1'b0;
      end else if (!en || chg) begin
         cnt  <= '0;
         sclk <= 1'b0;
         tick <= 1'b0;
      end else if (cnt == term) begin
         cnt  <= '0;
         sclk <= ~sclk;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term);
   // R8
   tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (sclk != $past(sclk)));
   // R7
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (!sclk && !tick));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
   import sbg_pkg::*;
#(
   parameter int RATIO_W = 16,
   parameter int BRG_MIN = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               use_solver,
   input  logic [1:0]         man_div,
   input  logic [5:0]         man_brg,
   input  logic [RATIO_W-1:0] ratio,
   output logic               sclk,
   output logic               tick,
   output logic [1:0]         div_out,
   output logic [5:0]         brg_out
);
   if (RATIO_W < BRG_W + 2) begin : g_bad_ratio
      $error("ratio width too narrow for the rate field");
   end
   if (BRG_MIN < 1 || BRG_MIN >= (1 << BRG_W)) begin : g_bad_min
      $error("rate floor outside the rate field");
   end
   if (DIV_W != 2 || BRG_W != 6) begin : g_bad_fields
      $error("port widths assume a 2-bit prescale and 6-bit rate field");
   end

   sbg_cfg_t sol;
   sbg_cfg_t cfg;
   logic     chg;

   sbg_solver #(.RATIO_W(RATIO_W), .BRG_MIN(BRG_MIN)) u_solver (
      .ratio (ratio),
      .sol   (sol)
   );

   sbg_select #(.BRG_MIN(BRG_MIN)) u_select (
      .clk        (clk),
      .rst_n      (rst_n),
      .use_solver (use_solver),
      .man_div    (man_div),
      .man_brg    (man_brg),
      .sol        (sol),
      .cfg        (cfg),
      .chg        (chg)
   );

   sbg_divider u_divider (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .chg   (chg),
      .cfg   (cfg),
      .sclk  (sclk),
      .tick  (tick)
   );

   assign div_out = cfg.div;
   assign brg_out = cfg.brg;
endmodule

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        use_solver = 1'b0;
   logic [1:0]  man_div = '0;
   logic [5:0]  man_brg = '0;
   logic [15:0] ratio = '0;
   logic        sclk, tick;
   logic [1:0]  div_out;
   logic [5:0]  brg_out;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   spi_baud_gen u_spi_baud_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .use_solver(use_solver),
      .man_div(man_div), .man_brg(man_brg), .ratio(ratio),
      .sclk(sclk), .tick(tick), .div_out(div_out), .brg_out(brg_out)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic        mode;
      logic [1:0]  mdiv;
      logic [5:0]  mbrg;
      logic [15:0] rat;
      logic [1:0]  ediv;
      logic [5:0]  ebrg;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  1'b0, 2'd0, 6'd4,  16'd0,    2'd0, 6'd4 },  // R2 fastest
      '{4'd3,  1'b0, 2'd0, 6'd2,  16'd0,    2'd0, 6'd4 },  // R3 clamp
      '{4'd2,  1'b0, 2'd2, 6'd10, 16'd0,    2'd2, 6'd10},  // R2
      '{4'd2,  1'b0, 2'd3, 6'd63, 16'd0,    2'd3, 6'd63},  // R2 slowest
      '{4'd4,  1'b1, 2'd0, 6'd0,  16'd20,   2'd0, 6'd4 },  // R4
      '{4'd5,  1'b1, 2'd0, 6'd0,  16'd10,   2'd0, 6'd4 },  // R5
      '{4'd4,  1'b1, 2'd0, 6'd0,  16'd259,  2'd0, 6'd63},  // R4
      '{4'd10, 1'b1, 2'd3, 6'd0,  16'd260,  2'd1, 6'd31},  // R10 manual ignored
      '{4'd4,  1'b1, 2'd0, 6'd0,  16'd600,  2'd2, 6'd36},  // R4
      '{4'd4,  1'b1, 2'd0, 6'd0,  16'd2047, 2'd3, 6'd62},  // R4
      '{4'd6,  1'b1, 2'd0, 6'd0,  16'd5000, 2'd3, 6'd63},  // R6
      '{4'd5,  1'b1, 2'd1, 6'd9,  16'd0,    2'd0, 6'd4 },  // R5 zero ratio
      '{4'd10, 1'b0, 2'd1, 6'd0,  16'd5000, 2'd1, 6'd4 }   // R10 ratio ignored
   };

   function automatic int half_of(input logic [1:0] d, input logic [5:0] b);
      return (int'(b) + 1) << (int'(d) + 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tick && n < 5000);
   endtask

   initial begin
      int n;
      logic s0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(div_out == 2'd0 && brg_out == 6'd4, "R1", {div_out, brg_out}, 4);
      check(!sclk && !tick, "R1", {sclk, tick}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 idle hold while disabled
      man_div = 2'd0; man_brg = 6'd4;
      begin
         int bad = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sclk || tick) bad++;
         end
         check(bad == 0, "R7", bad, 0);
      end

      // R9 first change one half period after enable rises
      man_div = 2'd0; man_brg = 6'd10;
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_tick(n);
      check(n == 22, "R9", n, 22);
      check(sclk == 1'b1, "R8", sclk, 1);

      // table walk
      for (int v = 0; v < NV; v++) begin
         int h;
         use_solver = VEC[v].mode;
         man_div    = VEC[v].mdiv;
         man_brg    = VEC[v].mbrg;
         ratio      = VEC[v].rat;
         @(negedge clk);
         @(negedge clk);
         check(div_out == VEC[v].ediv && brg_out == VEC[v].ebrg,
               $sformatf("R%0d", VEC[v].req), {div_out, brg_out},
               {VEC[v].ediv, VEC[v].ebrg});
         h = half_of(VEC[v].ediv, VEC[v].ebrg);
         wait_tick(n);
         s0 = sclk;
         wait_tick(n);
         check(n == h, "R2", n, h);
         check(sclk != s0, "R8", sclk, !s0);
      end

      // R9 restart on a configuration change mid-period
      use_solver = 1'b0; man_div = 2'd0; man_brg = 6'd10;
      @(negedge clk);
      wait_tick(n);
      wait_tick(n);
      repeat (5) @(negedge clk);
      man_brg = 6'd20;
      @(negedge clk);
      check(sclk == 1'b0 && brg_out == 6'd20, "R9", {sclk, brg_out}, 20);
      wait_tick(n);
      check(n == 42, "R9", n, 42);

      // R7 disable mid-run
      @(negedge clk);
      en = 1'b0;
      begin
         int bad = 0;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sclk || tick) bad++;
         end
         check(bad == 0, "R7", bad, 0);
      end

      // R8 tick width: never two ticks in a row at fastest rate
      man_brg = 6'd4; man_div = 2'd0;
      en = 1'b1;
      begin
         int dbl = 0;
         logic prev = 1'b0;
         for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (prev && tick) dbl++;
            prev = tick;
         end
         check(dbl == 0, "R8", dbl, 0);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule